// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port through which an external controller reads and writes the internal control and status registers of a larger design. The controller raises an active-high select, drives a serial clock and a serial data line, and gets read data back on a serial output. That output is driven only during the data phase of a read. The register file is outside this block. On a write the block gives it a one-cycle strobe with address and data. On a read it gives a one-cycle request with the address and captures the returned byte.

Every transfer is one frame of sixteen bits, sent least significant bit first within each field. The first bit is the mode: 1 means read and 0 means write. Seven address bits follow, then eight data bits. For a read, the eight data slots carry the register contents back on the output instead. All serial inputs are resampled into the system clock domain. The system clock must therefore run at least four times faster than the serial clock. Input bits are taken on serial clock rising edges. Output bits change after falling edges.

Top module: `srp_port`

## Requirements
- R1: When select is low, the output enable `sdo_oe` is low, so the pad is high-impedance.
- R2: While select is low, the serial clock and data input have no effect. No strobe or request is issued, and the next frame decodes from its first bit.
- R3: Input bits are taken on serial clock rising edges. Bit 0 is the mode (1 = read, 0 = write), bits 1 to 7 are address bits 0 to 6, and bits 8 to 15 are data bits 0 to 7.
- R4: After the sixteenth rising edge of a write frame, `wr_stb` is high for exactly one system clock with the frame's `reg_addr` and `wr_data`. This happens only if select is still high.
- R5: After the eighth rising edge of a read frame, `rd_stb` is high for exactly one system clock with the frame's `reg_addr`. `rd_data` is taken during that cycle.
- R6: In a read frame, data bit k appears on `sdo` after the falling edge that follows rising edge 8+k and is held until the next falling edge. Data goes out least significant bit first, and `sdo_oe` is high from the first of those falling edges until select drops.
- R7: If select falls before the frame is complete, the transfer is aborted. Nothing is written, and the bit counter returns to zero.
- R8: Serial clock edges after the sixteenth bit of a frame are ignored until select goes low. They produce no second strobe.
- R9: After reset, `sdo_oe`, `sdo`, `wr_stb` and `rd_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Active-high select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdin | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| wr_stb | output | 1 | One-cycle register write strobe |
| rd_stb | output | 1 | One-cycle register read request |
| reg_addr | output | ADDR_W | Register address of the current frame |
| wr_data | output | DATA_W | Write data, valid with `wr_stb` |
| rd_data | input | DATA_W | Read data from the register file, valid while `rd_stb` is high |

## Verification
The hardest case to reach is a frame that does not end normally. That covers a select that falls after twelve bits, and a select held high while the clock keeps running beyond sixteen bits. In both cases any false write appears as an unexpected strobe, not as a wrong value. The driver task therefore takes a bit count that can be shorter or longer than a frame. The monitor treats any strobe not queued by the driver as a failure. Each abort is followed by a read of the same address, which shows that the register kept its old value and that the next frame decodes from bit 0. A burst of serial clock and data activity with select low is followed the same way, by a normal frame.

// File: rtl/srp_pkg.sv
// Package: shared types and frame geometry for the serial register port.
// Assumes fields are sent least significant bit first within each field.
package srp_pkg;

    // Mode bit carried in the first slot of every frame
    typedef enum logic {
        SRP_OP_WRITE = 1'b0,
        SRP_OP_READ  = 1'b1
    } srp_op_e;

    // Total frame length: mode bit, address field, data field
    function automatic int srp_frame_bits(input int addr_w, input int data_w);
        return 1 + addr_w + data_w;
    endfunction

endpackage

// File: rtl/srp_sync.sv
// Module: multi-bit resynchroniser.
// Each input bit passes through STAGES flip-flops in the system clock domain.
// Assumes the inputs are slow relative to clk (at least four clk per level).
module srp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Move each bit one stage further along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/srp_edge.sv
// Module: serial clock edge detector.
// Turns a resynchronised serial clock into one-cycle rise and fall pulses.
// Assumes the input is already in the clk domain.
module srp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    // Hold the previous serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

endmodule

// File: rtl/srp_rx.sv
// Module: frame receiver.
// Counts rising edges, collects the mode, address and data bits LSB first,
// and issues the write strobe or read request. Deselect clears the frame.
// Assumes rise pulses are one clk wide and sdin_s is aligned with them.
module srp_rx
    import srp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int FRAME  = srp_frame_bits(ADDR_W, DATA_W),
    parameter int CNT_W  = $clog2(FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              rise,
    input  logic              sdin_s,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              rd_phase,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME);

    srp_op_e op;

    // Position counter: advances per rising edge, saturates at a full frame
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)               bit_cnt <= '0;
        else if (rise && bit_cnt != FULL)   bit_cnt <= bit_cnt + 1'b1;
    end

    // Field capture: mode in slot 0, then address, then data, LSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op       <= SRP_OP_WRITE;
            reg_addr <= '0;
            wr_data  <= '0;
        end else if (sel_s && rise && bit_cnt != FULL) begin
            if (bit_cnt == '0)
                op <= srp_op_e'(sdin_s);
            else if (bit_cnt <= LAST_ADDR)
                reg_addr <= {sdin_s, reg_addr[ADDR_W-1:1]};
            else
                wr_data  <= {sdin_s, wr_data[DATA_W-1:1]};
        end
    end

    // Strobe generation: one-cycle pulses at the end of each field
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s) begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
        end else begin
            wr_stb <= rise && bit_cnt == LAST_BIT  && op == SRP_OP_WRITE;
            rd_stb <= rise && bit_cnt == LAST_ADDR && op == SRP_OP_READ;
        end
    end

    // Read data phase flag: set once the address of a read is complete
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)
            rd_phase <= 1'b0;
        else if (rise && bit_cnt == LAST_ADDR && op == SRP_OP_READ)
            rd_phase <= 1'b1;
    end

endmodule

// File: rtl/srp_tx.sv
// Module: read data transmitter.
// Captures register data on the read request, then shifts it out LSB first,
// one bit per serial clock falling edge, and drives the output enable.
// Assumes at least one clk separates rd_stb from the next fall pulse.
module srp_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              rd_stb,
    input  logic              rd_phase,
    input  logic              fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    logic [DATA_W-1:0] shreg;

    // Shift register: load on request, empty one bit per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)         shreg <= '0;
        else if (rd_stb)              shreg <= rd_data;
        else if (fall && rd_phase)    shreg <= {1'b0, shreg[DATA_W-1:1]};
    end

    // Output bit and enable: update only on falling edges during a read
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (fall && rd_phase) begin
            sdo    <= shreg[0];
            sdo_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/srp_port.sv
// Module: serial register access port (top).
// Resynchronises the select, clock and data inputs, detects clock edges,
// decodes frames and returns read data. The pad buffer drives sdo when
// sdo_oe is high and floats otherwise.
// Assumes clk runs at least four times faster than sclk, and that rd_data
// is valid combinationally while rd_stb is high.
module srp_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int FRAME = srp_pkg::srp_frame_bits(ADDR_W, DATA_W);
    localparam int CNT_W = $clog2(FRAME + 1);

    logic [2:0]       sync_out;
    logic             sel_s, sclk_s, sdin_s;
    logic             sclk_rise, sclk_fall;
    logic             rd_phase;
    logic [CNT_W-1:0] bit_cnt;

    srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel, sclk, sdin}),
        .dout (sync_out)
    );

    assign {sel_s, sclk_s, sdin_s} = sync_out;

    srp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(sclk_s),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    srp_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME(FRAME), .CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_s   (sel_s),
        .rise    (sclk_rise),
        .sdin_s  (sdin_s),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .rd_phase(rd_phase),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .bit_cnt (bit_cnt)
    );

    srp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_s   (sel_s),
        .rd_stb  (rd_stb),
        .rd_phase(rd_phase),
        .fall    (sclk_fall),
        .rd_data (rd_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

endmodule

// File: rtl/srp_port_chk.sv
// Module: property checker for srp_port, attached by bind.
// Watches the resynchronised select, the edge pulses and the port outputs.
module srp_port_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_s,
    input logic             sclk_fall,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic [CNT_W-1:0] bit_cnt
);

    // R1: output enable drops one cycle after select is seen low
    p_oe_off_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !sdo_oe);

    // R3: a frame is either a read or a write, never both
    p_one_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

    // R4: write strobe lasts one cycle
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4: write strobe only while select was seen high
    p_wr_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sel_s));

    // R5: read request lasts one cycle
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R6: output bit only changes after a falling edge or deselect
    p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sdo_oe) && !$past(sclk_fall) && $past(sel_s)) |-> $stable(sdo));

    // R7: deselect returns the bit counter to zero
    p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> bit_cnt == '0);

endmodule

bind srp_port srp_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .sclk_fall(sclk_fall),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .bit_cnt  (bit_cnt)
);

// File: tb/srp_port_test.sv
// Bench: scoreboard for srp_port. The driver queues the expected strobes and
// read values, and the monitor compares what the port produces.
module srp_port_test;

    localparam int AW = 7;
    localparam int DW = 8;
    localparam int NREG = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          sclk = 1'b0;
    logic          sdin = 1'b0;
    logic          sdo, sdo_oe, wr_stb, rd_stb;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] wr_data, rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [AW+DW-1:0] wr_q[$];
    logic [AW-1:0]    rd_q[$];
    logic [DW-1:0]    exp_mem[NREG];
    logic [DW-1:0]    regs[NREG];

    always #4 clk = ~clk;

    srp_port #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
        .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // Register array model on the far side of the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= DW'(i * 37 + 5);
        end else if (wr_stb) begin
            regs[reg_addr] <= wr_data;
        end
    end
    assign rd_data = regs[reg_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare strobes against the scoreboard queues
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_stb) begin
                if (wr_q.size() == 0)
                    check(1'b0, "R4/R2/R7/R8 unexpected write", int'({reg_addr, wr_data}), 0);
                else begin
                    logic [AW+DW-1:0] e;
                    e = wr_q.pop_front();
                    check({reg_addr, wr_data} == e, "R3/R4 write addr/data",
                          int'({reg_addr, wr_data}), int'(e));
                end
            end
            if (rst_n && rd_stb) begin
                if (rd_q.size() == 0)
                    check(1'b0, "R5/R2 unexpected read", int'(reg_addr), 0);
                else begin
                    logic [AW-1:0] e;
                    e = rd_q.pop_front();
                    check(reg_addr == e, "R5 read addr", int'(reg_addr), int'(e));
                end
            end
        end
    end

    // Driver: one frame of nbits serial bits; extra bits beyond 16 are ones
    task automatic frame(input bit op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int nbits);
        logic [AW+DW:0] bits;
        logic [DW-1:0]  got;
        bits = {d, a, op};
        got = '0;
        if (!op && nbits >= AW + DW + 1) begin
            wr_q.push_back({a, d});
            exp_mem[a] = d;
        end
        if (op && nbits >= AW + 1) rd_q.push_back(a);
        sel = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i <= AW + DW) ? (op && i > AW ? 1'b0 : bits[i]) : 1'b1;
            repeat (5) @(negedge clk);
            if (op && i > AW && i <= AW + DW) begin
                got[i-AW-1] = sdo;
                check(sdo_oe == 1'b1, "R6 enable in data phase", int'(sdo_oe), 1);
            end
            sclk = 1'b1;
            repeat (5) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        sel = 1'b0;
        repeat (4) @(negedge clk);
        check(sdo_oe == 1'b0, "R1 enable off after deselect", int'(sdo_oe), 0);
        repeat (4) @(negedge clk);
        if (op && nbits >= AW + DW + 1)
            check(got == exp_mem[a], "R6 read data LSB first", int'(got), int'(exp_mem[a]));
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_mem[i] = DW'(i * 37 + 5);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9: reset state
        check(!sdo_oe && !sdo && !wr_stb && !rd_stb, "R9 reset outputs",
              int'({sdo_oe, sdo, wr_stb, rd_stb}), 0);

        // R3/R6: read an initial value, then writes with varied patterns
        frame(1'b1, 7'h05, '0, 16);
        frame(1'b0, 7'h05, 8'hA5, 16);
        frame(1'b1, 7'h05, '0, 16);
        frame(1'b0, 7'h7F, 8'h01, 16);
        frame(1'b0, 7'h00, 8'h80, 16);
        frame(1'b1, 7'h7F, '0, 16);
        frame(1'b1, 7'h00, '0, 16);
        frame(1'b1, 7'h2A, '0, 16);

        // R2: activity with select low has no effect
        for (int i = 0; i < 20; i++) begin
            sdin = i[0];
            sclk = ~sclk;
            repeat (5) @(negedge clk);
            check(sdo_oe == 1'b0, "R1/R2 enable off while deselected", int'(sdo_oe), 0);
        end
        sclk = 1'b0;
        repeat (6) @(negedge clk);
        frame(1'b0, 7'h11, 8'h3C, 16);
        frame(1'b1, 7'h11, '0, 16);

        // R7: abort mid-frame, then confirm nothing was written
        frame(1'b0, 7'h11, 8'hFF, 12);
        frame(1'b1, 7'h11, '0, 16);
        frame(1'b0, 7'h12, 8'h00, 15);
        frame(1'b1, 7'h12, '0, 16);

        // R8: extra clocks after a full frame give no second strobe
        frame(1'b0, 7'h33, 8'h5A, 22);
        frame(1'b1, 7'h33, '0, 16);

        repeat (10) @(negedge clk);
        check(wr_q.size() == 0, "R4 all writes seen", wr_q.size(), 0);
        check(rd_q.size() == 0, "R5 all reads seen", rd_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule